// File: doc/BRIEF.md
# Calendar clock with alarm

This block keeps time of day and the calendar date. A once-per-second counter holds seconds, minutes, hours (0..23), day of week, day of month, month and a two-digit year, all in binary inside the block. A register copy of these seven values is shown to software. The copy is shown either in BCD or in plain binary, and the hours are shown in 24-hour or 12-hour style. Two mode inputs choose the format.

The block counts a 32768 Hz tick enable. After every `TICKS_PER_SEC` ticks a second boundary occurs. When the oscillator-mode field permits it, the internal counter steps by one second at that boundary and raises the update-in-progress flag. `UPD_DELAY` ticks later the visible registers are refreshed, unless a freeze input holds them. The alarm and update-ended events are then evaluated and the update-in-progress flag drops. Software can set the time by writing single registers. Each write is loaded into the counter at once. While the freeze input is high the written values only collect in the registers, and they reach the counter when the freeze input is released.

Top module: `rtc_calendar`

## Requirements
- R1: After a synchronous reset the registers show 00:00:00, day of week 0, day 01, month 01, year 00. `uip` and all interrupt flags are 0.
- R2: A second boundary occurs on every `TICKS_PER_SEC`-th tick. The counter advances at a boundary only when `osc_mode` equals 3'b010; with any other code the boundary passes and nothing changes.
- R3: `uip` rises at an advancing boundary when `set_mode` is low. It falls on the `UPD_DELAY`-th tick after that boundary, together with the register refresh.
- R4: At the end of each update the seven time registers are rewritten from the counter, unless `set_mode` is high. Otherwise they change only by a write.
- R5: With `bin_mode`=1 the values are plain binary; with 0 they are BCD. With `h24_mode`=1 hours show 0..23. With 0 they show hour modulo 12, and bit 7 of the hours byte is set for hours 12..23. The same formats are used to decode written bytes.
- R6: Seconds wrap at 60, minutes at 60 and hours at 24. Day of week counts 0..6 and then returns to 0. The day of month returns to 1 after the last day of the month, the month returns to 1 after 12, and the year returns to 00 after 99. February has 29 days when 2000 plus the year is divisible by 4, except a multiple of 100 that is not a multiple of 400.
- R7: At the end of an update with `alarm_ie`=1, the alarm matches when each of the three alarm bytes either has bits 7:6 equal to 2'b11 (don't care) or decodes to the current counter value (hours compared as 0..23). A match sets `int_flags[1]` and `int_flags[2]`.
- R8: At the end of every update with `update_ie`=1, `int_flags[0]` and `int_flags[2]` are set. An alarm and an update-ended event may be flagged in the same update.
- R9: A write with `wr_sel` 0..6 targets seconds, minutes, hours, day of week, day of month, month and year, in that order; `wr_sel`=7 is ignored. With `set_mode` low the written register set is loaded into the counter in the same cycle. With `set_mode` high it is only stored, and it is loaded on the falling edge of `set_mode`.
- R10: `flag_ack` clears all three interrupt flags. A flag that is set in the same cycle stays set.
- R11: `irq` is high exactly when `int_flags[2]` is set, and `int_flags[2]` is set only together with at least one source flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 32768 Hz tick enable |
| osc_mode | input | 3 | Oscillator mode; 3'b010 lets time run |
| set_mode | input | 1 | Freeze: holds the registers and defers loading |
| bin_mode | input | 1 | 1 = binary, 0 = BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| alarm_ie | input | 1 | Alarm event enable |
| update_ie | input | 1 | Update-ended event enable |
| wr_en | input | 1 | Time register write strobe |
| wr_sel | input | 3 | Written register select |
| wr_data | input | 8 | Written byte |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| flag_ack | input | 1 | Clears the interrupt flags |
| t_sec | output | 8 | Seconds register |
| t_min | output | 8 | Minutes register |
| t_hour | output | 8 | Hours register |
| t_wday | output | 8 | Day-of-week register |
| t_mday | output | 8 | Day-of-month register |
| t_month | output | 8 | Month register |
| t_year | output | 8 | Year register |
| uip | output | 1 | Update-in-progress flag |
| int_flags | output | 3 | {any, alarm, update-ended} |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- `uip` rises only at an advancing boundary while the block is not frozen.
- `uip` falls only at the end of an update, and stays high only while an update is pending.
- Each event flag rises only at the end of an update with its enable set.
- An acknowledge clears the flags.
- The summary flag never stands alone.
- The seconds register changes only by a write or a refresh.

Calendar correctness is shown only by the bench's scenarios, which compare every output with a behavioural model on each clock. This covers leap and non-leap February, the end-of-century year wrap, the binary and 12-hour formats, the effect of the oscillator-mode field and freeze-mode loading.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam logic [2:0] OSC_RUN   = 3'b010;
    localparam int         NUM_TREGS = 7;

    typedef enum logic [2:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_WDAY = 3'd3,
        SEL_MDAY = 3'd4,
        SEL_MON  = 3'd5,
        SEL_YEAR = 3'd6
    } tsel_e;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] dom;
        logic [2:0] dow;
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } cal_t;

    localparam cal_t CAL_RESET = '{yr: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd0,
                                  hr: 5'd0, mn: 6'd0, sc: 6'd0};

    // binary value -> presented byte
    function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

    // presented byte -> binary value
    function automatic logic [7:0] dec(input logic [7:0] b, input logic bin);
        return bin ? b : (8'(b[7:4]) * 8'd10 + 8'(b[3:0]));
    endfunction

    function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                            input logic h24);
        logic [7:0] r;
        if (h24) begin
            r = enc({2'b00, h}, bin);
        end else begin
            r = enc(7'(h % 5'd12), bin);
            r[7] = (h >= 5'd12);
        end
        return r;
    endfunction

    function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin,
                                            input logic h24);
        logic [7:0] v;
        v = dec({1'b0, b[6:0]}, bin);
        if (!h24 && b[7]) v = v + 8'd12;
        return v[4:0];
    endfunction

    function automatic logic is_leap(input logic [6:0] yr);
        int full;
        full = 2000 + int'(yr);
        return ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
        case (mon)
            4'd2:                      return is_leap(yr) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

    function automatic cal_t cal_next(input cal_t c);
        cal_t n;
        n = c;
        if (c.sc < 6'd59) begin
            n.sc = c.sc + 6'd1;
        end else begin
            n.sc = 6'd0;
            if (c.mn < 6'd59) begin
                n.mn = c.mn + 6'd1;
            end else begin
                n.mn = 6'd0;
                if (c.hr < 5'd23) begin
                    n.hr = c.hr + 5'd1;
                end else begin
                    n.hr  = 5'd0;
                    n.dow = (c.dow >= 3'd6) ? 3'd0 : c.dow + 3'd1;
                    if (c.dom < month_days(c.mon, c.yr)) begin
                        n.dom = c.dom + 5'd1;
                    end else begin
                        n.dom = 5'd1;
                        if (c.mon < 4'd12) begin
                            n.mon = c.mon + 4'd1;
                        end else begin
                            n.mon = 4'd1;
                            n.yr  = (c.yr >= 7'd99) ? 7'd0 : c.yr + 7'd1;
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_tick_seq.sv
module rtc_tick_seq #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UPD_DELAY     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run_en,
    output logic step,
    output logic fire,
    output logic pending
);
    localparam int DW = $clog2(TICKS_PER_SEC);
    localparam int PW = $clog2(UPD_DELAY + 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(TICKS_PER_SEC - 1);
    localparam logic [PW-1:0] DLY_LAST = PW'(UPD_DELAY - 1);

    logic [DW-1:0] div_q;
    logic [PW-1:0] dly_q;
    logic          pend_q;
    logic          bnd;

    assign bnd     = tick && (div_q == DIV_LAST);
    assign step    = bnd && run_en;
    assign fire    = tick && pend_q && (dly_q == DLY_LAST);
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            dly_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (tick) div_q <= bnd ? '0 : div_q + 1'b1;
            if (fire) begin
                pend_q <= 1'b0;
            end else if (tick && pend_q) begin
                dly_q <= dly_q + 1'b1;
            end
            if (step) begin
                pend_q <= 1'b1;
                dly_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cal_t load_val,
    input  logic step,
    output cal_t cal
);
    always_ff @(posedge clk) begin
        if (rst)       cal <= CAL_RESET;
        else if (load) cal <= load_val;
        else if (step) cal <= cal_next(cal);
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_cal_pkg::*;
(
    input  cal_t       cal,
    input  logic       bin,
    input  logic [7:0] a_sec,
    input  logic [7:0] a_min,
    input  logic [7:0] a_hour,
    output logic       match
);
    logic [2:0] hit;
    logic [7:0] a_b [3];
    logic [7:0] cur [3];

    assign a_b[0] = a_sec;
    assign a_b[1] = a_min;
    assign a_b[2] = a_hour;
    assign cur[0] = {2'b00, cal.sc};
    assign cur[1] = {2'b00, cal.mn};
    assign cur[2] = {3'b000, cal.hr};

    for (genvar i = 0; i < 3; i++) begin : g_field
        assign hit[i] = (a_b[i][7:6] == 2'b11) || (dec(a_b[i], bin) == cur[i]);
    end

    assign match = &hit;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UPD_DELAY     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [2:0] osc_mode,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       alarm_ie,
    input  logic       update_ie,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic       flag_ack,
    output logic [7:0] t_sec,
    output logic [7:0] t_min,
    output logic [7:0] t_hour,
    output logic [7:0] t_wday,
    output logic [7:0] t_mday,
    output logic [7:0] t_month,
    output logic [7:0] t_year,
    output logic       uip,
    output logic [2:0] int_flags,
    output logic       irq
);
    logic       upd_step, upd_fire, upd_pend;
    logic       run_en, set_prev, wr_hit, cal_load, alarm_hit;
    cal_t       cal, ld_val;
    logic [7:0] treg  [NUM_TREGS];
    logic [7:0] nreg  [NUM_TREGS];
    logic [7:0] fmt_b [NUM_TREGS];
    logic [7:0] reset_b [NUM_TREGS];

    assign run_en = (osc_mode == OSC_RUN);

    rtc_tick_seq #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UPD_DELAY    (UPD_DELAY)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run_en (run_en),
        .step   (upd_step),
        .fire   (upd_fire),
        .pending(upd_pend)
    );

    // counter image formatted for presentation
    always_comb begin
        fmt_b[SEL_SEC]  = enc({1'b0, cal.sc}, bin_mode);
        fmt_b[SEL_MIN]  = enc({1'b0, cal.mn}, bin_mode);
        fmt_b[SEL_HOUR] = enc_hour(cal.hr, bin_mode, h24_mode);
        fmt_b[SEL_WDAY] = enc({4'b0, cal.dow}, bin_mode);
        fmt_b[SEL_MDAY] = enc({2'b0, cal.dom}, bin_mode);
        fmt_b[SEL_MON]  = enc({3'b0, cal.mon}, bin_mode);
        fmt_b[SEL_YEAR] = enc(cal.yr, bin_mode);
        reset_b[SEL_SEC]  = 8'h00;
        reset_b[SEL_MIN]  = 8'h00;
        reset_b[SEL_HOUR] = 8'h00;
        reset_b[SEL_WDAY] = 8'h00;
        reset_b[SEL_MDAY] = 8'h01;
        reset_b[SEL_MON]  = 8'h01;
        reset_b[SEL_YEAR] = 8'h00;
    end

    assign wr_hit = wr_en && (wr_sel != 3'd7);

    for (genvar i = 0; i < NUM_TREGS; i++) begin : g_treg
        logic hit_i;
        assign hit_i   = wr_en && (wr_sel == 3'(i));
        assign nreg[i] = hit_i ? wr_data : treg[i];
        always_ff @(posedge clk) begin
            if (rst)                          treg[i] <= reset_b[i];
            else if (hit_i)                   treg[i] <= wr_data;
            else if (upd_fire && !set_mode)   treg[i] <= fmt_b[i];
        end
    end

    // register set (with this cycle's write) decoded into the counter
    always_comb begin
        ld_val.sc  = 6'(dec(nreg[SEL_SEC],  bin_mode));
        ld_val.mn  = 6'(dec(nreg[SEL_MIN],  bin_mode));
        ld_val.hr  = dec_hour(nreg[SEL_HOUR], bin_mode, h24_mode);
        ld_val.dow = 3'(dec(nreg[SEL_WDAY], bin_mode));
        ld_val.dom = 5'(dec(nreg[SEL_MDAY], bin_mode));
        ld_val.mon = 4'(dec(nreg[SEL_MON],  bin_mode));
        ld_val.yr  = 7'(dec(nreg[SEL_YEAR], bin_mode));
    end

    assign cal_load = !set_mode && (wr_hit || set_prev);

    rtc_cal_core u_core (
        .clk     (clk),
        .rst     (rst),
        .load    (cal_load),
        .load_val(ld_val),
        .step    (upd_step),
        .cal     (cal)
    );

    rtc_alarm_cmp u_alarm (
        .cal   (cal),
        .bin   (bin_mode),
        .a_sec (alm_sec),
        .a_min (alm_min),
        .a_hour(alm_hour),
        .match (alarm_hit)
    );

    logic [2:0] flag_set;
    always_comb begin
        flag_set[1] = upd_fire && alarm_ie && alarm_hit;
        flag_set[0] = upd_fire && update_ie;
        flag_set[2] = flag_set[1] || flag_set[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_prev  <= 1'b0;
            uip       <= 1'b0;
            int_flags <= 3'b000;
        end else begin
            set_prev <= set_mode;
            if (upd_fire)                   uip <= 1'b0;
            else if (upd_step && !set_mode) uip <= 1'b1;
            int_flags <= (flag_ack ? 3'b000 : int_flags) | flag_set;
        end
    end

    assign irq     = int_flags[2];
    assign t_sec   = treg[SEL_SEC];
    assign t_min   = treg[SEL_MIN];
    assign t_hour  = treg[SEL_HOUR];
    assign t_wday  = treg[SEL_WDAY];
    assign t_mday  = treg[SEL_MDAY];
    assign t_month = treg[SEL_MON];
    assign t_year  = treg[SEL_YEAR];
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst,
    input logic       set_mode,
    input logic       alarm_ie,
    input logic       update_ie,
    input logic       flag_ack,
    input logic       wr_en,
    input logic       step,
    input logic       fire,
    input logic       pending,
    input logic       uip,
    input logic [2:0] int_flags,
    input logic [7:0] t_sec
);
    p_uip_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(uip) |-> ($past(step) && !$past(set_mode)));

    p_uip_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(uip) |-> $past(fire));

    p_uip_busy_r3: assert property (@(posedge clk) disable iff (rst)
        uip |-> pending);

    p_alarm_src_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(int_flags[1]) |-> ($past(fire) && $past(alarm_ie)));

    p_upd_src_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(int_flags[0]) |-> ($past(fire) && $past(update_ie)));

    p_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_ack) && !$past(fire)) |-> (int_flags == 3'b000));

    p_any_src_r11: assert property (@(posedge clk) disable iff (rst)
        int_flags[2] |-> (int_flags[1] || int_flags[0]));

    p_sec_change_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(t_sec) |-> ($past(wr_en) || $past(fire)));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .set_mode (set_mode),
    .alarm_ie (alarm_ie),
    .update_ie(update_ie),
    .flag_ack (flag_ack),
    .wr_en    (wr_en),
    .step     (upd_step),
    .fire     (upd_fire),
    .pending  (upd_pend),
    .uip      (uip),
    .int_flags(int_flags),
    .t_sec    (t_sec)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TPS = 40;
    localparam int DLY = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] osc_mode = 3'b010;
    logic       set_mode = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
    logic       alarm_ie = 1'b0, update_ie = 1'b0, wr_en = 1'b0, flag_ack = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
    logic [7:0] t_sec, t_min, t_hour, t_wday, t_mday, t_month, t_year;
    logic       uip, irq;
    logic [2:0] int_flags;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar #(.TICKS_PER_SEC(TPS), .UPD_DELAY(DLY)) u_rtc_calendar (
        .clk(clk), .rst(rst), .tick(tick), .osc_mode(osc_mode), .set_mode(set_mode),
        .bin_mode(bin_mode), .h24_mode(h24_mode), .alarm_ie(alarm_ie),
        .update_ie(update_ie), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .flag_ack(flag_ack),
        .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_wday(t_wday),
        .t_mday(t_mday), .t_month(t_month), .t_year(t_year), .uip(uip),
        .int_flags(int_flags), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_div, m_pend, m_dly, m_uip, m_fl, m_prev_set;
    int m_s, m_m, m_h, m_dw, m_dm, m_mo, m_y;
    int m_reg [7];

    function automatic int fmt(int v);
        return bin_mode ? v : (v / 10) * 16 + (v % 10);
    endfunction
    function automatic int unfmt(int b);
        return bin_mode ? b : (b / 16) * 10 + (b % 16);
    endfunction
    function automatic int fmt_hr(int h);
        if (h24_mode) return fmt(h);
        return fmt(h % 12) + ((h >= 12) ? 128 : 0);
    endfunction
    function automatic int unfmt_hr(int b);
        int v;
        v = unfmt(b % 128);
        if (!h24_mode && b >= 128) v += 12;
        return v;
    endfunction
    function automatic int mdays(int mo, int y);
        int full;
        full = 2000 + y;
        if (mo == 2)
            return ((full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0))) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction
    function automatic bit fld_ok(int b, int v);
        return ((b / 64) == 3) || (unfmt(b) == v);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_pend = 0; m_dly = 0; m_uip = 0; m_fl = 0; m_prev_set = 0;
            m_s = 0; m_m = 0; m_h = 0; m_dw = 0; m_dm = 1; m_mo = 1; m_y = 0;
            m_reg = '{0, 0, 0, 0, 1, 1, 0};
        end else begin
            bit step, fire, bnd, ld;
            int nr [7];
            int sets;
            step = 0; fire = 0; sets = 0;
            if (tick) begin
                bnd = (m_div == TPS - 1);
                m_div = bnd ? 0 : m_div + 1;
                if (m_pend != 0) begin
                    if (m_dly == DLY - 1) begin fire = 1; m_pend = 0; end
                    else m_dly++;
                end
                if (bnd && osc_mode == 3'b010) begin step = 1; m_pend = 1; m_dly = 0; end
            end
            nr = m_reg;
            if (wr_en && wr_sel != 7) nr[wr_sel] = wr_data;
            ld = !set_mode && ((wr_en && wr_sel != 7) || m_prev_set != 0);
            if (fire) begin
                if (alarm_ie && fld_ok(alm_sec, m_s) && fld_ok(alm_min, m_m) && fld_ok(alm_hour, m_h))
                    sets |= 3'b110;
                if (update_ie) sets |= 3'b101;
                if (!set_mode)
                    m_reg = '{fmt(m_s), fmt(m_m), fmt_hr(m_h), fmt(m_dw), fmt(m_dm), fmt(m_mo), fmt(m_y)};
            end
            if (wr_en && wr_sel != 7) m_reg[wr_sel] = wr_data;
            m_fl = (flag_ack ? 0 : m_fl) | sets;
            if (fire) m_uip = 0;
            else if (step && !set_mode) m_uip = 1;
            if (ld) begin
                m_s = unfmt(nr[0]); m_m = unfmt(nr[1]); m_h = unfmt_hr(nr[2]);
                m_dw = unfmt(nr[3]); m_dm = unfmt(nr[4]); m_mo = unfmt(nr[5]); m_y = unfmt(nr[6]);
            end else if (step) begin
                if (m_s < 59) m_s++;
                else begin
                    m_s = 0;
                    if (m_m < 59) m_m++;
                    else begin
                        m_m = 0;
                        if (m_h < 23) m_h++;
                        else begin
                            m_h = 0;
                            m_dw = (m_dw >= 6) ? 0 : m_dw + 1;
                            if (m_dm < mdays(m_mo, m_y)) m_dm++;
                            else begin
                                m_dm = 1;
                                if (m_mo < 12) m_mo++;
                                else begin m_mo = 1; m_y = (m_y >= 99) ? 0 : m_y + 1; end
                            end
                        end
                    end
                end
            end
            m_prev_set = set_mode;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 t_sec",   t_sec,   m_reg[0]);
            chk("R4 t_min",   t_min,   m_reg[1]);
            chk("R4 t_hour",  t_hour,  m_reg[2]);
            chk("R4 t_wday",  t_wday,  m_reg[3]);
            chk("R4 t_mday",  t_mday,  m_reg[4]);
            chk("R4 t_month", t_month, m_reg[5]);
            chk("R4 t_year",  t_year,  m_reg[6]);
            chk("R3 uip",     uip,     m_uip);
            chk("R7/R8 int_flags", int_flags, m_fl);
            chk("R11 irq",    irq,     (m_fl >> 2) & 1);
        end
    end

    always @(posedge clk) cyc++;
    always @(negedge clk) tick <= rst ? 1'b0 : ~tick;

    // ---------------- stimulus helpers ----------------
    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(int sel, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_updates(int n);
        int seen;
        logic prev;
        seen = 0;
        prev = uip;
        while (seen < n) begin
            @(negedge clk);
            if (prev && !uip) seen++;
            prev = uip;
        end
    endtask

    task automatic write_all(int s, int m, int h, int dw, int dm, int mo, int y);
        wr(0, s); wr(1, m); wr(2, h); wr(3, dw); wr(4, dm); wr(5, mo); wr(6, y);
    endtask

    initial begin
        wait (cyc == 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        cycles(4);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset t_sec", t_sec, 8'h00);
        chk("R1 reset t_mday", t_mday, 8'h01);
        chk("R1 reset t_month", t_month, 8'h01);
        chk("R1 reset uip", uip, 0);
        chk("R1 reset flags", int_flags, 0);

        // R6 / R9: leap February 2000, loaded on release of set_mode
        wait_updates(1);
        set_mode = 1'b1;
        write_all(8'h58, 8'h59, 8'h23, 8'h06, 8'h28, 8'h02, 8'h00);
        @(negedge clk) set_mode = 1'b0;
        wait_updates(2);
        chk("R6 leap day", t_mday, 8'h29);
        chk("R6 leap month", t_month, 8'h02);
        chk("R6 hour wrap", t_hour, 8'h00);
        chk("R6 weekday wrap", t_wday, 8'h00);

        // R6 / R9: non-leap 2001, immediate loads
        wait_updates(1);
        write_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h01);
        wait_updates(1);
        chk("R6 nonleap mday", t_mday, 8'h01);
        chk("R6 nonleap month", t_month, 8'h03);

        // R6: year end wrap 99 -> 00
        wait_updates(1);
        write_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h99);
        wait_updates(1);
        chk("R6 year wrap", t_year, 8'h00);
        chk("R6 month wrap", t_month, 8'h01);
        chk("R6 day wrap", t_mday, 8'h01);

        // R5: binary, 12-hour, 2 PM
        wait_updates(1);
        set_mode = 1'b1; bin_mode = 1'b1; h24_mode = 1'b0;
        wr(2, 8'h82); wr(1, 45); wr(0, 10);
        @(negedge clk) set_mode = 1'b0;
        wait_updates(1);
        chk("R5 12h pm hour", t_hour, 8'h82);
        chk("R5 binary min", t_min, 8'h2D);
        chk("R5 binary sec", t_sec, 8'h0B);
        bin_mode = 1'b0; h24_mode = 1'b1;
        wait_updates(1);
        chk("R5 24h bcd hour", t_hour, 8'h14);

        // R2: oscillator mode off, nothing moves
        held = t_sec;
        osc_mode = 3'b000;
        cycles(200);
        chk("R2 frozen sec", t_sec, held);
        chk("R2 no uip", uip, 0);
        osc_mode = 3'b010;

        // R9 / R4: set_mode holds the registers, release loads them
        wait_updates(1);
        set_mode = 1'b1;
        wr(0, 8'h30);
        wr(7, 8'h55);
        cycles(100);
        chk("R4 held under set", t_sec, 8'h30);
        @(negedge clk) set_mode = 1'b0;
        wait_updates(1);
        chk("R9 loaded on release", t_sec, 8'h31);

        // R7 / R8 / R11: alarm with don't-care fields plus update-ended
        alm_sec = 8'hC0; alm_min = 8'hC0; alm_hour = 8'h14;
        alarm_ie = 1'b1; update_ie = 1'b1;
        wait_updates(1);
        chk("R7 alarm and R8 update flags", int_flags, 3'b111);
        chk("R11 irq high", irq, 1);
        @(negedge clk) flag_ack = 1'b1;
        @(negedge clk) flag_ack = 1'b0;
        chk("R10 flags cleared", int_flags, 3'b000);
        chk("R11 irq low", irq, 0);
        alm_hour = 8'h05;
        wait_updates(1);
        chk("R7 hour mismatch", int_flags, 3'b101);
        alarm_ie = 1'b0; update_ie = 1'b0;
        @(negedge clk) flag_ack = 1'b1;
        @(negedge clk) flag_ack = 1'b0;
        cycles(100);
        chk("R8 disabled no flags", int_flags, 3'b000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule